// File: doc/BRIEF.md
# Segment Base Register Unit

This unit keeps three hidden 64-bit segment base addresses: a base for the first extra data segment (slot F), a base for the second extra data segment (slot G), and a shadow kernel copy of the slot G base (slot K). Software reads and writes all three through a model-specific-register port that takes a 32-bit register index. A write supplies the new value as separate low and high 32-bit halves.

A segment load passes an 8-byte code/data descriptor to the unit. The unit rebuilds the 32-bit base from the fields that the descriptor scatters, and it writes only the low 32 bits of the chosen slot. A privileged exchange request swaps the slot G and slot K contents in a single clock edge. The unit drives the effective base of slots F and G continuously for address formation. In compatibility mode only the low half of each base counts. In 64-bit mode the whole value counts.

Top module: `seg_base_unit`

## Requirements
- R1: Reset clears the slot F, slot G and slot K bases to zero.
- R2: When `msr_wr` is high and `msr_idx` is 0xC0000100 (slot F), 0xC0000101 (slot G) or 0xC0000102 (slot K), the next clock edge loads the whole 64-bit slot with {`msr_whi`, `msr_wlo`}. This happens in either mode.
- R3: `msr_rdata` shows, in the same cycle and without a clock edge, the current value of the slot that `msr_idx` selects.
- R4: Any other index sets `msr_fault` in the same cycle, provided `msr_rd` or `msr_wr` is high. For such an index `msr_rdata` reads zero and a write leaves all three slots unchanged.
- R5: A descriptor load (`ld_en`, with `ld_sel` 0 for slot F and 1 for slot G) writes base bits 15:0 from descriptor bits 31:16, base bits 23:16 from bits 39:32, and base bits 31:24 from bits 63:56, into bits 31:0 of the slot.
- R6: A descriptor load leaves bits 63:32 of the slot unchanged.
- R7: With `mode64` low, `eff_f` and `eff_g` carry the low 32 bits of their slot with the upper 32 bits at zero. With `mode64` high they carry the full 64-bit value.
- R8: A `swap_req` with `cpl` equal to 0 and `mode64` high exchanges the slot G and slot K contents at the next edge.
- R9: A `swap_req` with nonzero `cpl`, or with `mode64` low, changes no slot. It raises `swap_fault` for exactly the one cycle after the request.
- R10: A legal swap request in a cycle that also has `msr_wr` or `ld_en` high lets that write take effect first. The exchange then happens at the following edge, provided that cycle carries no write.
- R11: When a register write and a descriptor load hit the same slot in one cycle, the register write wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = compatibility mode |
| cpl | input | 2 | Current privilege level |
| msr_wr | input | 1 | Register write strobe |
| msr_rd | input | 1 | Register read strobe (drives fault reporting) |
| msr_idx | input | 32 | Register index |
| msr_wlo | input | 32 | Write data, low half |
| msr_whi | input | 32 | Write data, high half |
| msr_rdata | output | 64 | Read data for `msr_idx` |
| msr_fault | output | 1 | Access to an unsupported index |
| ld_en | input | 1 | Descriptor load strobe |
| ld_sel | input | 1 | Load target: 0 slot F, 1 slot G |
| ld_desc | input | 64 | 8-byte code/data descriptor |
| swap_req | input | 1 | Exchange request for slots G and K |
| swap_fault | output | 1 | Illegal exchange, one-cycle pulse |
| eff_f | output | 64 | Effective base for slot F |
| eff_g | output | 64 | Effective base for slot G |

## Verification
On every cycle the assertions check these properties:
- An exchange trades the slot G and slot K values.
- A load keeps the upper half of its slot.
- Compatibility mode zeroes the upper half of the effective bases.
- An unsupported index reads zero.
- An illegal request never swaps and produces a fault pulse.
- A request held back by a write is not lost.

Some behaviour shows only in the bench's scenarios, checked against its behavioural model:
- The field scatter of descriptor loads.
- The exact value that ends up in each slot after a write, a load and a deferred exchange land on consecutive edges.
- The priority when a register write and a load hit the same slot.

// File: rtl/seg_base_pkg.sv
package seg_base_pkg;
   localparam int SLOT_N = 3;
   localparam int LO_W   = 32;
   localparam int DESC_W = 64;

   typedef enum logic [1:0] {
      SLOT_F = 2'd0,
      SLOT_G = 2'd1,
      SLOT_K = 2'd2
   } slot_e;
endpackage

// File: rtl/seg_desc_base.sv
module seg_desc_base
   import seg_base_pkg::*;
(
   input  logic [DESC_W-1:0] desc,
   output logic [LO_W-1:0]   base
);
   // positions of the split base fields inside the descriptor
   localparam int B0_LSB = 16;
   localparam int B0_W   = 16;
   localparam int B1_LSB = 32;
   localparam int B1_W   = 8;
   localparam int B2_LSB = 56;
   localparam int B2_W   = 8;

   if (B0_W + B1_W + B2_W != LO_W) begin : g_bad_split
      $error("descriptor base fields must total LO_W bits");
   end

   always_comb begin
      base = '0;
      base[B0_W-1:0]                  = desc[B0_LSB +: B0_W];
      base[B0_W +: B1_W]              = desc[B1_LSB +: B1_W];
      base[B0_W + B1_W +: B2_W]       = desc[B2_LSB +: B2_W];
   end
endmodule

// File: rtl/seg_msr_decode.sv
module seg_msr_decode
   import seg_base_pkg::*;
#(
   parameter int               IDX_W = 32,
   parameter logic [IDX_W-1:0] IDX_F = 32'hC000_0100,
   parameter logic [IDX_W-1:0] IDX_G = 32'hC000_0101,
   parameter logic [IDX_W-1:0] IDX_K = 32'hC000_0102
)(
   input  logic [IDX_W-1:0]  idx,
   output logic [SLOT_N-1:0] hit_vec,
   output logic              hit
);
   localparam logic [IDX_W-1:0] IDX_TAB [SLOT_N] = '{IDX_F, IDX_G, IDX_K};

   if (IDX_F == IDX_G || IDX_F == IDX_K || IDX_G == IDX_K) begin : g_bad_idx
      $error("register indices must be distinct");
   end

   for (genvar s = 0; s < SLOT_N; s++) begin : g_cmp
      assign hit_vec[s] = (idx == IDX_TAB[s]);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/seg_swap_ctl.sv
module seg_swap_ctl #(
   parameter int CPL_W = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             swap_req,
   input  logic [CPL_W-1:0] cpl,
   input  logic             mode64,
   input  logic             hold,
   output logic             swap_do,
   output logic             swap_fault
);
   if (CPL_W < 1) begin : g_bad_cpl
      $error("CPL_W must be at least 1");
   end

   logic legal;
   logic pend_q;
   logic want;

   assign legal   = swap_req && (cpl == '0) && mode64;
   assign want    = legal || pend_q;
   assign swap_do = want && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         swap_fault <= 1'b0;
      end else begin
         pend_q     <= want && hold;
         swap_fault <= swap_req && !legal;
      end
   end

   a_r9_fault_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      swap_fault |-> $past(swap_req));
   a_r9_illegal_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_req && ((cpl != '0) || !mode64) && !pend_q) |-> !swap_do);
   a_r10_held_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
      (legal && hold) |=> (swap_do || hold));
endmodule

// File: rtl/seg_base_bank.sv
module seg_base_bank
   import seg_base_pkg::*;
#(
   parameter int BASE_W = 64
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SLOT_N-1:0]             wr_vec,
   input  logic [BASE_W-1:0]             wdata,
   input  logic [SLOT_N-1:0]             ld_vec,
   input  logic [LO_W-1:0]               ld_lo,
   input  logic                          swap_do,
   output logic [SLOT_N-1:0][BASE_W-1:0] q
);
   localparam int HI_W = BASE_W - LO_W;

   if (BASE_W <= LO_W) begin : g_bad_w
      $error("BASE_W must exceed LO_W");
   end

   for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
      if (s == int'(SLOT_F)) begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[s] <= '0;
            else if (wr_vec[s]) q[s] <= wdata;
            else if (ld_vec[s]) q[s][LO_W-1:0] <= ld_lo;
         end
      end else begin : g_swappable
         localparam int PEER = (s == int'(SLOT_G)) ? int'(SLOT_K) : int'(SLOT_G);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[s] <= '0;
            else if (wr_vec[s]) q[s] <= wdata;
            else if (ld_vec[s]) q[s][LO_W-1:0] <= ld_lo;
            else if (swap_do)   q[s] <= q[PEER];
         end
      end

      a_r6_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_vec[s] && !wr_vec[s]) |=> (q[s][BASE_W-1 -: HI_W] == $past(q[s][BASE_W-1 -: HI_W])));
   end

   a_r8_swap_trades: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_do && (wr_vec == '0) && (ld_vec == '0)) |=>
         (q[SLOT_G] == $past(q[SLOT_K]) && q[SLOT_K] == $past(q[SLOT_G])));
endmodule

// File: rtl/seg_eff_select.sv
module seg_eff_select
   import seg_base_pkg::*;
#(
   parameter int BASE_W = 64
)(
   input  logic              mode64,
   input  logic [BASE_W-1:0] base,
   output logic [BASE_W-1:0] eff
);
   always_comb begin
      eff = base;
      if (!mode64) eff[BASE_W-1:LO_W] = '0;
   end

   a_r7_compat_hi_zero: assert final (mode64 || eff[BASE_W-1:LO_W] == '0);
endmodule

// File: rtl/seg_base_unit.sv
module seg_base_unit
   import seg_base_pkg::*;
#(
   parameter int               BASE_W = 64,
   parameter int               IDX_W  = 32,
   parameter int               CPL_W  = 2,
   parameter logic [IDX_W-1:0] IDX_F  = 32'hC000_0100,
   parameter logic [IDX_W-1:0] IDX_G  = 32'hC000_0101,
   parameter logic [IDX_W-1:0] IDX_K  = 32'hC000_0102
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mode64,
   input  logic [CPL_W-1:0]       cpl,
   input  logic                   msr_wr,
   input  logic                   msr_rd,
   input  logic [IDX_W-1:0]       msr_idx,
   input  logic [LO_W-1:0]        msr_wlo,
   input  logic [BASE_W-LO_W-1:0] msr_whi,
   output logic [BASE_W-1:0]      msr_rdata,
   output logic                   msr_fault,
   input  logic                   ld_en,
   input  logic                   ld_sel,
   input  logic [DESC_W-1:0]      ld_desc,
   input  logic                   swap_req,
   output logic                   swap_fault,
   output logic [BASE_W-1:0]      eff_f,
   output logic [BASE_W-1:0]      eff_g
);
   logic [SLOT_N-1:0]             hit_vec;
   logic                          hit;
   logic [SLOT_N-1:0]             wr_vec;
   logic [SLOT_N-1:0]             ld_vec;
   logic [LO_W-1:0]               ld_lo;
   logic                          swap_do;
   logic [SLOT_N-1:0][BASE_W-1:0] q;
   logic [1:0][BASE_W-1:0]        eff_vec;

   seg_msr_decode #(.IDX_W(IDX_W), .IDX_F(IDX_F), .IDX_G(IDX_G), .IDX_K(IDX_K)) i_dec (
      .idx(msr_idx), .hit_vec(hit_vec), .hit(hit));

   seg_desc_base i_desc (.desc(ld_desc), .base(ld_lo));

   assign wr_vec    = msr_wr ? hit_vec : '0;
   assign msr_fault = (msr_wr || msr_rd) && !hit;

   always_comb begin
      ld_vec = '0;
      if (ld_en) ld_vec[ld_sel ? int'(SLOT_G) : int'(SLOT_F)] = 1'b1;
   end

   seg_swap_ctl #(.CPL_W(CPL_W)) i_swap (
      .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .cpl(cpl), .mode64(mode64),
      .hold(msr_wr || ld_en), .swap_do(swap_do), .swap_fault(swap_fault));

   seg_base_bank #(.BASE_W(BASE_W)) i_bank (
      .clk(clk), .rst_n(rst_n), .wr_vec(wr_vec), .wdata({msr_whi, msr_wlo}),
      .ld_vec(ld_vec), .ld_lo(ld_lo), .swap_do(swap_do), .q(q));

   always_comb begin
      msr_rdata = '0;
      for (int s = 0; s < SLOT_N; s++)
         if (hit_vec[s]) msr_rdata = msr_rdata | q[s];
   end

   for (genvar e = 0; e < 2; e++) begin : g_eff
      seg_eff_select #(.BASE_W(BASE_W)) i_eff (
         .mode64(mode64), .base(q[e]), .eff(eff_vec[e]));
   end

   assign eff_f = eff_vec[0];
   assign eff_g = eff_vec[1];

   a_r4_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      msr_fault |-> (msr_rdata == '0));
   a_r9_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_fault && !$past(swap_req, 2)) |=> !swap_fault || $past(swap_req));
endmodule

// File: tb/test_seg_base_unit.sv
`timescale 1ns/1ps
module test_seg_base_unit;
   localparam logic [31:0] IF = 32'hC000_0100;
   localparam logic [31:0] IG = 32'hC000_0101;
   localparam logic [31:0] IK = 32'hC000_0102;

   logic clk = 0;
   logic rst_n = 0;
   logic mode64 = 1, msr_wr = 0, msr_rd = 0, ld_en = 0, ld_sel = 0, swap_req = 0;
   logic [1:0]  cpl = 0;
   logic [31:0] msr_idx = IF, msr_wlo = 0, msr_whi = 0;
   logic [63:0] ld_desc = 0;
   logic [63:0] msr_rdata, eff_f, eff_g;
   logic        msr_fault, swap_fault;

   int checks = 0, errors = 0;
   logic [63:0] m_reg [3];
   bit          m_pend, m_sfault;

   always #5 clk = ~clk;

   seg_base_unit i_seg_base_unit (
      .clk(clk), .rst_n(rst_n), .mode64(mode64), .cpl(cpl), .msr_wr(msr_wr),
      .msr_rd(msr_rd), .msr_idx(msr_idx), .msr_wlo(msr_wlo), .msr_whi(msr_whi),
      .msr_rdata(msr_rdata), .msr_fault(msr_fault), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_desc(ld_desc), .swap_req(swap_req), .swap_fault(swap_fault),
      .eff_f(eff_f), .eff_g(eff_g));

   function automatic int slot_of(input logic [31:0] idx);
      if (idx == IF) return 0;
      if (idx == IG) return 1;
      if (idx == IK) return 2;
      return -1;
   endfunction

   function automatic logic [63:0] make_desc(input logic [31:0] b, input logic [31:0] junk);
      logic [63:0] d;
      d = {junk, junk};
      d[31:16] = b[15:0];
      d[39:32] = b[23:16];
      d[63:56] = b[31:24];
      return d;
   endfunction

   function automatic logic [31:0] desc_base(input logic [63:0] d);
      return {d[63:56], d[39:32], d[31:16]};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input string tag);
      int s;
      logic [63:0] exp_rd, exp_f, exp_g, t;
      bit legal, hold;
      #1;
      s = slot_of(msr_idx);
      exp_rd = (s < 0) ? 64'h0 : m_reg[s];
      exp_f = mode64 ? m_reg[0] : {32'h0, m_reg[0][31:0]};
      exp_g = mode64 ? m_reg[1] : {32'h0, m_reg[1][31:0]};
      check({tag, " R3 rdata"}, msr_rdata, exp_rd);
      check("R4 msr_fault", {63'h0, msr_fault}, {63'h0, bit'((msr_wr || msr_rd) && s < 0)});
      check("R7 eff_f", eff_f, exp_f);
      check("R7 eff_g", eff_g, exp_g);
      check("R9 swap_fault", {63'h0, swap_fault}, {63'h0, m_sfault});
      @(posedge clk);
      legal = swap_req && cpl == 0 && mode64;
      hold  = msr_wr || ld_en;
      if (msr_wr && s >= 0) m_reg[s] = {msr_whi, msr_wlo};
      if (ld_en && !(msr_wr && s == int'(ld_sel)))
         m_reg[int'(ld_sel)][31:0] = desc_base(ld_desc);
      if ((legal || m_pend) && !hold) begin
         t = m_reg[1]; m_reg[1] = m_reg[2]; m_reg[2] = t;
      end
      m_pend   = (legal || m_pend) && hold;
      m_sfault = swap_req && !legal;
      @(negedge clk);
   endtask

   task automatic idle();
      msr_wr = 0; msr_rd = 0; ld_en = 0; swap_req = 0;
   endtask

   task automatic rd(input logic [31:0] idx, input string tag);
      idle(); msr_rd = 1; msr_idx = idx; step(tag); msr_rd = 0;
   endtask

   task automatic wr(input logic [31:0] idx, input logic [63:0] v, input string tag);
      idle(); msr_wr = 1; msr_idx = idx; msr_whi = v[63:32]; msr_wlo = v[31:0];
      step(tag); msr_wr = 0;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 3; i++) m_reg[i] = 0;
      m_pend = 0; m_sfault = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      rd(IF, "R1 reset F"); rd(IG, "R1 reset G"); rd(IK, "R1 reset K");

      wr(IF, 64'h1122_3344_5566_7788, "R2 write F");
      wr(IG, 64'hA5A5_0000_1234_5678, "R2 write G");
      wr(IK, 64'hFFFF_8000_CAFE_0001, "R2 write K");
      rd(IF, "R2 read F"); rd(IG, "R2 read G"); rd(IK, "R2 read K");

      rd(32'hC000_0103, "R4 bad read");
      wr(32'hC000_00FF, 64'hDEAD_DEAD_DEAD_DEAD, "R4 bad write");
      rd(IF, "R4 F intact"); rd(IG, "R4 G intact"); rd(IK, "R4 K intact");

      mode64 = 0;
      rd(IF, "R7 compat");
      idle(); ld_en = 1; ld_sel = 0; ld_desc = make_desc(32'hDEAD_BEEF, 32'h0F0F_0F0F);
      step("R5 load F");
      rd(IF, "R5 R6 F low new high kept");
      idle(); ld_en = 1; ld_sel = 1; ld_desc = make_desc(32'h0102_0304, 32'hFFFF_FFFF);
      step("R5 load G");
      rd(IG, "R6 G high kept");
      mode64 = 1;
      rd(IG, "R7 full");

      idle(); swap_req = 1; cpl = 0; step("R8 swap");
      rd(IG, "R8 G after swap"); rd(IK, "R8 K after swap");

      idle(); swap_req = 1; cpl = 3; step("R9 swap cpl3");
      cpl = 0; rd(IG, "R9 G unchanged");
      mode64 = 0; idle(); swap_req = 1; step("R9 swap compat");
      mode64 = 1; rd(IK, "R9 K unchanged");

      idle(); msr_wr = 1; msr_idx = IK; msr_whi = 32'h7777_6666; msr_wlo = 32'h5555_4444;
      swap_req = 1; step("R10 write plus swap");
      rd(IK, "R10 after deferred swap K"); rd(IG, "R10 after deferred swap G");

      idle(); ld_en = 1; ld_sel = 1; ld_desc = make_desc(32'h89AB_CDEF, 32'h0);
      swap_req = 1; step("R10 load plus swap");
      rd(IK, "R10 K gets loaded G"); rd(IG, "R10 G gets old K");

      idle(); msr_wr = 1; msr_idx = IF; msr_whi = 32'h1; msr_wlo = 32'h2;
      ld_en = 1; ld_sel = 0; ld_desc = make_desc(32'hFFFF_FFFF, 32'h0);
      step("R11 same slot");
      rd(IF, "R11 write wins");

      for (int n = 0; n < 400; n++) begin
         logic [31:0] r;
         r = $urandom;
         msr_wr = r[0]; msr_rd = r[1]; ld_en = r[2] & r[3]; ld_sel = r[4];
         swap_req = r[5] & r[6]; cpl = r[8:7]; mode64 = r[9] | r[10];
         case (r[12:11])
            2'd0: msr_idx = IF; 2'd1: msr_idx = IG; 2'd2: msr_idx = IK;
            default: msr_idx = 32'hC000_0100 + {30'h0, r[14:13]} + 32'h3;
         endcase
         msr_wlo = $urandom; msr_whi = $urandom;
         ld_desc = {$urandom, $urandom};
         step("R2 R5 R8 R10 random");
      end
      idle();
      for (int i = 0; i < 3; i++) rd(IF + i, "R3 final");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule